// File: doc/BRIEF.md
# Cache Debug Access Port

This block lets the processor reach the cache storage directly, bypassing tag matching. Software uses it to inspect or patch cache lines, gather usage statistics and manage tags, for example to invalidate every line of an address range that is being retired. An access is recognised by its address. When both of the two top address bits are set, the access is a debug access. The next two bits then pick one of four targets: the data RAM of either way, or the tag and line-info store of either way.

Debug addresses are split into fields in the same way as ordinary cache addresses. Bits [4:0] are the byte offset within a 32-byte line, and the line index sits directly above them. As a result, neighbouring tag entries are 32 bytes apart in the debug window. A tag access moves a 10-bit word in either direction. That word holds the tag, the valid flag, the line's dirty flag for that way, and the shared most-recent-way bit. The dirty flag changes only when the written word carries an explicit enable. The block does not contain the RAMs. It sits in front of them and shares them with the normal lookup path through a multiplexer. An active debug access takes the RAMs for its cycle and blocks the normal path for that cycle only.

Top module: `cache_dbg_port`

## Requirements
- R1: A request is accepted only when `dbg_addr[31]` and `dbg_addr[30]` are both 1. Any other request drives no RAM enable, raises no `dbg_ready` and leaves stored contents unchanged.
- R2: `dbg_addr[29:28]` selects the target: 0 = data way 0, 1 = data way 1, 2 = tag/info way 0, 3 = tag/info way 1.
- R3: Data accesses are 32 bits wide. The data RAM word address is {line index, `dbg_addr[4:2]`}, and each word of a line is stored and returned separately.
- R4: The line index is `dbg_addr[5 +: LINE_BITS]`, so consecutive tag entries are 32 bytes apart. Entries at adjacent indices are independent.
- R5: A tag read returns bit 9 = most-recent-way bit of the line, bit 8 = dirty flag of the addressed way, bit 7 = valid, bits [6:0] = tag.
- R6: A tag write always stores written bits [6:0] as the tag and bit 7 as valid.
- R7: A tag write changes the addressed way's dirty flag, to the value of written bit 8, only when written bit 9 is 1. It never changes the other way's dirty flag or the most-recent-way bit.
- R8: `dbg_ready` is high for exactly the one cycle after an accepted request. For a read, `dbg_rdata` holds the result in that cycle.
- R9: When no request is accepted, `nrm_granted` is 1 and every normal-path RAM signal passes through unchanged. While a request is accepted, `nrm_granted` is 0 and the RAMs carry the debug access.
- R10: While `rst_n` is low, `dbg_ready` is 0 at the following clock edge.
- R11: Bits [31:10] of a tag read result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_req | input | 1 | Debug access request, one cycle |
| dbg_we | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | 32 | Byte address of the access |
| dbg_wdata | input | 32 | Write data (tag word in bits [9:0]) |
| dbg_rdata | output | 32 | Read result, valid with dbg_ready |
| dbg_ready | output | 1 | Completion pulse |
| nrm_granted | output | 1 | Normal path owns the RAMs this cycle |
| nrm_dram_en | input | 2 | Normal data RAM enable per way |
| nrm_dram_we | input | 1 | Normal data RAM write |
| nrm_dram_addr | input | LINE_BITS+3 | Normal data RAM word address |
| nrm_dram_wdata | input | 32 | Normal data RAM write data |
| nrm_tag_addr | input | LINE_BITS | Normal tag/info line index |
| nrm_tram_en | input | 2 | Normal tag RAM enable per way |
| nrm_tram_we | input | 1 | Normal tag RAM write |
| nrm_tram_wdata | input | 8 | Normal tag RAM write data {valid, tag} |
| nrm_info_en | input | 1 | Normal info RAM enable |
| nrm_info_we | input | 1 | Normal info RAM write |
| nrm_info_wmask | input | 3 | Normal info bit write mask |
| nrm_info_wdata | input | 3 | Normal info write data {mru, dirty1, dirty0} |
| dram_en | output | 2 | Data RAM enable per way |
| dram_we | output | 1 | Data RAM write |
| dram_addr | output | LINE_BITS+3 | Data RAM word address |
| dram_wdata | output | 32 | Data RAM write data |
| dram_rdata_w0 | input | 32 | Data RAM way 0 read data (one cycle latency) |
| dram_rdata_w1 | input | 32 | Data RAM way 1 read data |
| tag_addr | output | LINE_BITS | Tag and info RAM line index |
| tram_en | output | 2 | Tag RAM enable per way |
| tram_we | output | 1 | Tag RAM write |
| tram_wdata | output | 8 | Tag RAM write data {valid, tag} |
| tram_rdata_w0 | input | 8 | Tag RAM way 0 read data |
| tram_rdata_w1 | input | 8 | Tag RAM way 1 read data |
| info_en | output | 1 | Info RAM enable |
| info_we | output | 1 | Info RAM write |
| info_wmask | output | 3 | Info RAM bit write mask |
| info_wdata | output | 3 | Info RAM write data |
| info_rdata | input | 3 | Info RAM read data {mru, dirty1, dirty0} |

## Verification
A fixed table of interleaved writes and reads is applied to both data ways and to neighbouring word offsets. Its results can only all match if the way bit and the word field are decoded independently. Tag writes with the dirty enable set and clear are read back through both ways. This separates a correct per-way masked dirty update from one that writes unconditionally or touches the wrong way. A preset most-recent-way bit must survive a tag write and appear in reads of both ways. Directed steps send requests that miss the window, and check that the normal-path signals pass through untouched until a debug access takes over.

// File: rtl/cdbg_pkg.sv
// Shared definitions for the cache debug access port.
// Assumes two ways and a fixed 7-bit tag, so the tag word is 10 bits.
package cdbg_pkg;
    typedef enum logic [1:0] {
        DEV_DATA0 = 2'd0,
        DEV_DATA1 = 2'd1,
        DEV_TAG0  = 2'd2,
        DEV_TAG1  = 2'd3
    } dbg_dev_e;

    localparam int TAG_W     = 7;
    localparam int TRAM_W    = TAG_W + 1;   // {valid, tag}
    localparam int INFO_W    = 3;           // {mru, dirty1, dirty0}
    localparam int TWORD_W   = 10;
    localparam int DATA_W    = 32;
    localparam int OFFSET_W  = 5;           // 32-byte lines
endpackage

// File: rtl/cdbg_decode.sv
// Address decoder for the debug window.
// Recognises the window, picks the target device and extracts line and word.
// Assumes LINE_BITS + 5 <= 28 so the line field sits below the device bits.
module cdbg_decode
    import cdbg_pkg::*;
#(
    parameter int LINE_BITS = 11
) (
    input  logic                 req,
    input  logic [31:0]          addr,
    output logic                 hit,
    output dbg_dev_e             dev,
    output logic [LINE_BITS-1:0] line,
    output logic [2:0]           word
);
    localparam int LINE_TOP = OFFSET_W + LINE_BITS;

    logic unused_addr;

    // Window match and field split.
    always_comb begin
        hit  = req && addr[31] && addr[30];
        dev  = dbg_dev_e'(addr[29:28]);
        line = addr[OFFSET_W +: LINE_BITS];
        word = addr[4:2];
    end

    assign unused_addr = ^{addr[27:LINE_TOP], addr[1:0]};
endmodule

// File: rtl/cdbg_tagfmt.sv
// Packs and unpacks the 10-bit tag/info word and applies the field write rules.
// Write word: [9] dirty enable, [8] dirty value, [7] valid, [6:0] tag.
// Read word:  [9] most-recent way, [8] dirty of this way, [7] valid, [6:0] tag.
module cdbg_tagfmt
    import cdbg_pkg::*;
(
    input  logic               wr_way,
    input  logic [TWORD_W-1:0] wword,
    output logic [TRAM_W-1:0]  tram_wdata,
    output logic               dirty_wen,
    output logic [INFO_W-1:0]  info_wmask,
    output logic [INFO_W-1:0]  info_wdata,
    input  logic               rd_way,
    input  logic [TRAM_W-1:0]  rd_tram,
    input  logic [INFO_W-1:0]  rd_info,
    output logic [TWORD_W-1:0] rword
);
    // Write side: tag and valid pass straight, dirty goes through a one-hot mask.
    always_comb begin
        tram_wdata = wword[TRAM_W-1:0];
        dirty_wen  = wword[9];
        info_wmask = '0;
        info_wmask[wr_way] = 1'b1;
        info_wdata = {1'b0, wword[8], wword[8]};
    end

    // Read side: merge the way's tag entry with the shared line info.
    always_comb begin
        rword = {rd_info[2], rd_info[rd_way], rd_tram};
    end
endmodule

// File: rtl/cdbg_arb.sv
// Two-input bus multiplexer for the shared RAM control signals.
// The debug side wins only while its select is high; otherwise the normal side passes.
module cdbg_arb #(
    parameter int W = 8
) (
    input  logic         dbg_sel,
    input  logic [W-1:0] dbg_bus,
    input  logic [W-1:0] nrm_bus,
    output logic [W-1:0] ram_bus,
    output logic         nrm_granted
);
    // Select the bus owner for this cycle.
    always_comb begin
        ram_bus     = dbg_sel ? dbg_bus : nrm_bus;
        nrm_granted = !dbg_sel;
    end
endmodule

// File: rtl/cache_dbg_port.sv
// Cache debug access port: direct processor access to data, tag and info RAMs.
// Assumes synchronous RAMs with one cycle read latency and a one-cycle request.
// Accepted requests complete with a dbg_ready pulse on the following cycle.
module cache_dbg_port
    import cdbg_pkg::*;
#(
    parameter int LINE_BITS = 11,
    parameter int DADDR_W   = LINE_BITS + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dbg_req,
    input  logic                 dbg_we,
    input  logic [31:0]          dbg_addr,
    input  logic [31:0]          dbg_wdata,
    output logic [31:0]          dbg_rdata,
    output logic                 dbg_ready,
    output logic                 nrm_granted,
    input  logic [1:0]           nrm_dram_en,
    input  logic                 nrm_dram_we,
    input  logic [DADDR_W-1:0]   nrm_dram_addr,
    input  logic [31:0]          nrm_dram_wdata,
    input  logic [LINE_BITS-1:0] nrm_tag_addr,
    input  logic [1:0]           nrm_tram_en,
    input  logic                 nrm_tram_we,
    input  logic [7:0]           nrm_tram_wdata,
    input  logic                 nrm_info_en,
    input  logic                 nrm_info_we,
    input  logic [2:0]           nrm_info_wmask,
    input  logic [2:0]           nrm_info_wdata,
    output logic [1:0]           dram_en,
    output logic                 dram_we,
    output logic [DADDR_W-1:0]   dram_addr,
    output logic [31:0]          dram_wdata,
    input  logic [31:0]          dram_rdata_w0,
    input  logic [31:0]          dram_rdata_w1,
    output logic [LINE_BITS-1:0] tag_addr,
    output logic [1:0]           tram_en,
    output logic                 tram_we,
    output logic [7:0]           tram_wdata,
    input  logic [7:0]           tram_rdata_w0,
    input  logic [7:0]           tram_rdata_w1,
    output logic                 info_en,
    output logic                 info_we,
    output logic [2:0]           info_wmask,
    output logic [2:0]           info_wdata,
    input  logic [2:0]           info_rdata
);
    localparam int BUS_W = 2 + 1 + DADDR_W + DATA_W + LINE_BITS
                         + 2 + 1 + TRAM_W + 1 + 1 + INFO_W + INFO_W;

    logic                 hit;
    dbg_dev_e             dev;
    logic [LINE_BITS-1:0] line;
    logic [2:0]           word;
    logic                 is_tag;
    logic                 way;
    logic [TRAM_W-1:0]    d_tram_wdata;
    logic                 dirty_wen;
    logic [INFO_W-1:0]    d_info_wmask;
    logic [INFO_W-1:0]    d_info_wdata;
    logic [1:0]           way_onehot;
    logic [1:0]           d_dram_en;
    logic [1:0]           d_tram_en;
    logic                 d_info_en;
    logic [BUS_W-1:0]     dbg_bus;
    logic [BUS_W-1:0]     nrm_bus;
    logic [BUS_W-1:0]     ram_bus;
    logic                 ready_q;
    dbg_dev_e             rd_dev_q;
    logic [TRAM_W-1:0]    rd_tram;
    logic [TWORD_W-1:0]   rword;

    cdbg_decode #(.LINE_BITS(LINE_BITS)) u_decode (
        .req  (dbg_req),
        .addr (dbg_addr),
        .hit  (hit),
        .dev  (dev),
        .line (line),
        .word (word)
    );

    cdbg_tagfmt u_tagfmt (
        .wr_way     (way),
        .wword      (dbg_wdata[TWORD_W-1:0]),
        .tram_wdata (d_tram_wdata),
        .dirty_wen  (dirty_wen),
        .info_wmask (d_info_wmask),
        .info_wdata (d_info_wdata),
        .rd_way     (rd_dev_q[0]),
        .rd_tram    (rd_tram),
        .rd_info    (info_rdata),
        .rword      (rword)
    );

    // Debug-side RAM controls derived from the decoded target.
    always_comb begin
        is_tag     = dev[1];
        way        = dev[0];
        way_onehot = way ? 2'b10 : 2'b01;
        d_dram_en  = (hit && !is_tag) ? way_onehot : 2'b00;
        d_tram_en  = (hit &&  is_tag) ? way_onehot : 2'b00;
        d_info_en  = hit && is_tag && (!dbg_we || dirty_wen);
    end

    // Flatten both request buses for the shared multiplexer.
    always_comb begin
        dbg_bus = {d_dram_en, dbg_we, {line, word}, dbg_wdata,
                   line, d_tram_en, dbg_we, d_tram_wdata,
                   d_info_en, dbg_we, d_info_wmask, d_info_wdata};
        nrm_bus = {nrm_dram_en, nrm_dram_we, nrm_dram_addr, nrm_dram_wdata,
                   nrm_tag_addr, nrm_tram_en, nrm_tram_we, nrm_tram_wdata,
                   nrm_info_en, nrm_info_we, nrm_info_wmask, nrm_info_wdata};
    end

    cdbg_arb #(.W(BUS_W)) u_arb (
        .dbg_sel     (hit),
        .dbg_bus     (dbg_bus),
        .nrm_bus     (nrm_bus),
        .ram_bus     (ram_bus),
        .nrm_granted (nrm_granted)
    );

    // Unpack the granted bus onto the RAM ports.
    assign {dram_en, dram_we, dram_addr, dram_wdata,
            tag_addr, tram_en, tram_we, tram_wdata,
            info_en, info_we, info_wmask, info_wdata} = ram_bus;

    // Completion pulse and target of the access in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q  <= 1'b0;
            rd_dev_q <= DEV_DATA0;
        end else begin
            ready_q <= hit;
            if (hit) rd_dev_q <= dev;
        end
    end

    // Return data selection, zero outside the completion cycle.
    always_comb begin
        rd_tram   = rd_dev_q[0] ? tram_rdata_w1 : tram_rdata_w0;
        dbg_rdata = '0;
        if (ready_q) begin
            case (rd_dev_q)
                DEV_DATA0: dbg_rdata = dram_rdata_w0;
                DEV_DATA1: dbg_rdata = dram_rdata_w1;
                DEV_TAG0,
                DEV_TAG1:  dbg_rdata = {{(DATA_W-TWORD_W){1'b0}}, rword};
                default:   dbg_rdata = '0;
            endcase
        end
    end

    assign dbg_ready = ready_q;

    AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ready |-> $past(dbg_req)); // R8
    AST_READY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ready |-> ($past(dbg_addr[31:30]) == 2'b11)); // R1
    AST_DIRTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (info_en && info_we && !nrm_granted) |-> (!info_wmask[2] && $countones(info_wmask) == 1)); // R7
    AST_NRM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !nrm_granted |-> ((dram_en | tram_en) != 2'b00)); // R9
    AST_TAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_ready && rd_dev_q[1]) |-> (dbg_rdata[31:10] == '0)); // R11
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !dbg_ready); // R10
endmodule

// File: tb/cache_dbg_port_tb_top.sv
module cache_dbg_port_tb_top;
    localparam int LB = 4;
    localparam int DW = LB + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbg_req = 1'b0, dbg_we = 1'b0;
    logic [31:0] dbg_addr = '0, dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic dbg_ready, nrm_granted;
    logic [1:0] nrm_dram_en = '0;
    logic nrm_dram_we = 1'b0;
    logic [DW-1:0] nrm_dram_addr = '0;
    logic [31:0] nrm_dram_wdata = '0;
    logic [LB-1:0] nrm_tag_addr = '0;
    logic [1:0] nrm_tram_en = '0;
    logic nrm_tram_we = 1'b0;
    logic [7:0] nrm_tram_wdata = '0;
    logic nrm_info_en = 1'b0, nrm_info_we = 1'b0;
    logic [2:0] nrm_info_wmask = '0, nrm_info_wdata = '0;
    logic [1:0] dram_en;
    logic dram_we;
    logic [DW-1:0] dram_addr;
    logic [31:0] dram_wdata, dram_q0, dram_q1;
    logic [LB-1:0] tag_addr;
    logic [1:0] tram_en;
    logic tram_we;
    logic [7:0] tram_wdata, tram_q0, tram_q1;
    logic info_en, info_we;
    logic [2:0] info_wmask, info_wdata, info_q;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cache_dbg_port #(.LINE_BITS(LB)) dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_we(dbg_we),
        .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .dbg_ready(dbg_ready), .nrm_granted(nrm_granted),
        .nrm_dram_en(nrm_dram_en), .nrm_dram_we(nrm_dram_we),
        .nrm_dram_addr(nrm_dram_addr), .nrm_dram_wdata(nrm_dram_wdata),
        .nrm_tag_addr(nrm_tag_addr), .nrm_tram_en(nrm_tram_en),
        .nrm_tram_we(nrm_tram_we), .nrm_tram_wdata(nrm_tram_wdata),
        .nrm_info_en(nrm_info_en), .nrm_info_we(nrm_info_we),
        .nrm_info_wmask(nrm_info_wmask), .nrm_info_wdata(nrm_info_wdata),
        .dram_en(dram_en), .dram_we(dram_we), .dram_addr(dram_addr),
        .dram_wdata(dram_wdata), .dram_rdata_w0(dram_q0), .dram_rdata_w1(dram_q1),
        .tag_addr(tag_addr), .tram_en(tram_en), .tram_we(tram_we),
        .tram_wdata(tram_wdata), .tram_rdata_w0(tram_q0), .tram_rdata_w1(tram_q1),
        .info_en(info_en), .info_we(info_we), .info_wmask(info_wmask),
        .info_wdata(info_wdata), .info_rdata(info_q)
    );

    // Bench RAM models, synchronous with one cycle read latency.
    logic [31:0] dmem0 [2**DW];
    logic [31:0] dmem1 [2**DW];
    logic [7:0]  tmem0 [2**LB];
    logic [7:0]  tmem1 [2**LB];
    logic [2:0]  imem  [2**LB];

    initial begin
        for (int i = 0; i < 2**DW; i++) begin dmem0[i] = '0; dmem1[i] = '0; end
        for (int i = 0; i < 2**LB; i++) begin tmem0[i] = '0; tmem1[i] = '0; imem[i] = '0; end
    end

    always @(posedge clk) begin
        if (dram_en[0]) begin if (dram_we) dmem0[dram_addr] <= dram_wdata; else dram_q0 <= dmem0[dram_addr]; end
        if (dram_en[1]) begin if (dram_we) dmem1[dram_addr] <= dram_wdata; else dram_q1 <= dmem1[dram_addr]; end
        if (tram_en[0]) begin if (tram_we) tmem0[tag_addr] <= tram_wdata; else tram_q0 <= tmem0[tag_addr]; end
        if (tram_en[1]) begin if (tram_we) tmem1[tag_addr] <= tram_wdata; else tram_q1 <= tmem1[tag_addr]; end
        if (info_en) begin
            if (info_we) imem[tag_addr] <= (imem[tag_addr] & ~info_wmask) | (info_wdata & info_wmask);
            else info_q <= imem[tag_addr];
        end
    end

    // Debug address: device in [29:28], line at bit 5, word at bit 2.
    function automatic logic [31:0] dadr(input logic [1:0] dev, input int line, input int word);
        return 32'hC000_0000 | (32'(dev) << 28) | (32'(line) << 5) | (32'(word) << 2);
    endfunction

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, dadr(2'd0, 3, 2), 32'hDEAD_BEEF, 32'h0},   // R2 way 0 data
        '{1'b1, dadr(2'd1, 3, 2), 32'h1234_5678, 32'h0},   // R2 way 1 data
        '{1'b0, dadr(2'd0, 3, 2), 32'h0, 32'hDEAD_BEEF},   // R3
        '{1'b0, dadr(2'd1, 3, 2), 32'h0, 32'h1234_5678},   // R3
        '{1'b1, dadr(2'd0, 3, 3), 32'hCAFE_F00D, 32'h0},   // R3 next word
        '{1'b0, dadr(2'd0, 3, 2), 32'h0, 32'hDEAD_BEEF},   // R3
        '{1'b0, dadr(2'd0, 3, 3), 32'h0, 32'hCAFE_F00D},   // R3
        '{1'b1, dadr(2'd2, 5, 0), 32'h3D5, 32'h0},         // R6 R7 dirty enabled
        '{1'b0, dadr(2'd2, 5, 0), 32'h0, 32'h1D5},         // R5 R11
        '{1'b1, dadr(2'd3, 5, 0), 32'h12A, 32'h0},         // R7 dirty not enabled
        '{1'b0, dadr(2'd3, 5, 0), 32'h0, 32'h02A},         // R7 dirty stays 0
        '{1'b0, dadr(2'd2, 5, 0), 32'h0, 32'h1D5},         // R7 other way intact
        '{1'b1, dadr(2'd2, 6, 0), 32'hFFFF_FC7F, 32'h0},   // R6 upper bits ignored
        '{1'b0, dadr(2'd2, 6, 0), 32'h0, 32'h07F},         // R11
        '{1'b1, dadr(2'd2, 8, 0), 32'h281, 32'h0},         // R4 adjacent lines
        '{1'b1, dadr(2'd2, 9, 0), 32'h3FE, 32'h0},         // R4
        '{1'b0, dadr(2'd2, 8, 0), 32'h0, 32'h081},         // R4
        '{1'b0, dadr(2'd2, 9, 0), 32'h0, 32'h1FE}          // R4
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One debug access; returns ready and data sampled in the completion cycle.
    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic rdy, output logic [31:0] rd);
        @(negedge clk);
        dbg_req = 1'b1; dbg_we = we; dbg_addr = addr; dbg_wdata = wd;
        @(negedge clk);
        dbg_req = 1'b0; dbg_we = 1'b0;
        rdy = dbg_ready;
        rd = dbg_rdata;
    endtask

    logic rdy;
    logic [31:0] rd;

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 ready in reset", 32'(dbg_ready), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 granted idle", 32'(nrm_granted), 32'h1);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata, rdy, rd);
            check("R8 ready pulse", 32'(rdy), 32'h1);
            if (!VECS[i].we)
                check(VECS[i].addr[29] ? "R5 tag read" : "R3 data read", rd, VECS[i].exp);
        end
        @(negedge clk);
        check("R8 ready drops", 32'(dbg_ready), 32'h0);

        // R1: outside the window, no enable, no ready, no change
        @(negedge clk);
        dbg_req = 1'b1; dbg_we = 1'b1; dbg_wdata = 32'h0;
        dbg_addr = dadr(2'd2, 5, 0) & 32'hBFFF_FFFF;
        #1;
        check("R1 tram_en off", 32'(tram_en), 32'h0);
        check("R1 granted kept", 32'(nrm_granted), 32'h1);
        @(negedge clk);
        dbg_req = 1'b0;
        check("R1 no ready", 32'(dbg_ready), 32'h0);
        access(1'b1, dadr(2'd0, 3, 2) & 32'h7FFF_FFFF, 32'h0, rdy, rd);
        check("R1 no ready high bit clear", 32'(rdy), 32'h0);
        access(1'b0, dadr(2'd2, 5, 0), 32'h0, rdy, rd);
        check("R1 tag unchanged", rd, 32'h1D5);
        access(1'b0, dadr(2'd0, 3, 2), 32'h0, rdy, rd);
        check("R1 data unchanged", rd, 32'hDEAD_BEEF);

        // R9: pass-through, then debug priority
        @(negedge clk);
        nrm_tram_en = 2'b01; nrm_tag_addr = 4'hA; nrm_dram_en = 2'b10; nrm_dram_addr = 7'h55;
        #1;
        check("R9 tag_addr pass", 32'(tag_addr), 32'hA);
        check("R9 dram_addr pass", 32'(dram_addr), 32'h55);
        check("R9 tram_en pass", 32'(tram_en), 32'h1);
        @(negedge clk);
        dbg_req = 1'b1; dbg_we = 1'b0; dbg_addr = dadr(2'd3, 2, 0);
        #1;
        check("R9 granted low", 32'(nrm_granted), 32'h0);
        check("R9 debug tag_addr", 32'(tag_addr), 32'h2);
        check("R9 debug tram_en", 32'(tram_en), 32'h2);
        check("R9 normal data blocked", 32'(dram_en), 32'h0);
        @(negedge clk);
        dbg_req = 1'b0;
        nrm_tram_en = '0; nrm_dram_en = '0;

        // R5 R7: most-recent-way bit reported and never written
        imem[7] = 3'b100;
        access(1'b1, dadr(2'd3, 7, 0), 32'h3FF, rdy, rd);
        access(1'b0, dadr(2'd3, 7, 0), 32'h0, rdy, rd);
        check("R5 mru way1 read", rd, 32'h3FF);
        access(1'b0, dadr(2'd2, 7, 0), 32'h0, rdy, rd);
        check("R7 mru kept, way0 dirty clear", rd, 32'h200);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule